// File: doc/BRIEF.md
# Tag-Based Reservation Station Buffer

This block is a small pool of waiting slots for out-of-order issue. Each cycle the allocation port can write one decoded operation into the pool: an opcode, a destination tag and three source operands. Two of them are data operands and the third is a condition operand that carries no data, such as a flags or memory-ordering dependency. A source whose tag is zero is already available: its value comes in on the allocation port. A source with a non-zero tag waits for the in-flight producer that the tag names.

A single result broadcast bus carries a tag and a value. Every cycle, each waiting operand compares its tag with the bus. On a match it captures the value and marks itself valid. An operation being allocated snoops the same bus in its write cycle, so a result produced in that cycle still reaches it.

A slot asserts its ready line once all three sources are valid. An external selector picks among the ready slots and returns a one-hot grant. In the grant cycle the block shows the granted operation on its issue outputs and frees the slot at the next clock edge.

Top module: `rs_pool`

## Requirements
- R1: After reset, no slot is occupied: `ent_ready` is all zero and `full` is low.
- R2: An accepted allocation is written into the lowest-numbered free slot, including a slot that a grant has just freed.
- R3: `full` is high exactly when all slots are occupied. An allocation presented while `full` is high is discarded and occupies no slot later.
- R4: A source tag of zero means the value on the allocation port is valid now. A non-zero tag leaves that source waiting.
- R5: A valid broadcast whose tag equals a waiting source tag captures the broadcast value and marks that source valid. Both data sources of one slot wake on the same broadcast when they share the tag.
- R6: An allocation that carries a non-zero tag equal to the tag of a valid broadcast in the same cycle captures that value at once, and the slot is ready on the next cycle.
- R7: `ent_ready[i]` is high only while slot i is occupied and all three of its sources are valid. The condition source wakes by tag alone.
- R8: A grant on a ready slot drives `iss_valid` high with that slot's opcode, destination tag and both operand values in the same cycle. The slot is free from the next cycle on.
- R9: A grant on a slot that is not ready leaves `iss_valid` low and leaves the slot occupied.
- R10: A broadcast with `bcast_valid` low, or with tag zero, wakes nothing.
- R11: A ready slot stays ready until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request this cycle |
| alloc_op | input | 8 | Opcode of the new operation |
| alloc_dst | input | 6 | Destination tag of the new operation |
| alloc_a_tag | input | 6 | Producer tag of source A, 0 = value supplied |
| alloc_a_val | input | 32 | Value of source A when its tag is 0 |
| alloc_b_tag | input | 6 | Producer tag of source B, 0 = value supplied |
| alloc_b_val | input | 32 | Value of source B when its tag is 0 |
| alloc_c_tag | input | 6 | Producer tag of the condition source, 0 = satisfied |
| full | output | 1 | No free slot; allocations are discarded |
| bcast_valid | input | 1 | Result broadcast present |
| bcast_tag | input | 6 | Tag of the broadcast result |
| bcast_val | input | 32 | Value of the broadcast result |
| ent_ready | output | 8 | Per-slot ready request to the selector |
| grant | input | 8 | One-hot grant from the selector |
| iss_valid | output | 1 | Granted slot was ready and is issuing |
| iss_op | output | 8 | Opcode of the issuing operation |
| iss_dst | output | 6 | Destination tag of the issuing operation |
| iss_a | output | 32 | Source A value of the issuing operation |
| iss_b | output | 32 | Source B value of the issuing operation |

## Verification
The assertions assume that the selector never grants more than one slot in a cycle. This constraint is itself checked as an input property, and the stimulus only ever raises a single grant bit. They also assume that the producer tags given to waiting sources are non-zero and refer to results not yet broadcast. The stimulus gives each in-flight tag a single broadcast and uses tag zero only for values that are already known.

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int N  = 8,
  parameter int TW = 6,
  parameter int VW = 32,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic [OW-1:0] alloc_op,
  input  logic [TW-1:0] alloc_dst,
  input  logic [TW-1:0] alloc_a_tag,
  input  logic [VW-1:0] alloc_a_val,
  input  logic [TW-1:0] alloc_b_tag,
  input  logic [VW-1:0] alloc_b_val,
  input  logic [TW-1:0] alloc_c_tag,
  output logic          full,
  input  logic          bcast_valid,
  input  logic [TW-1:0] bcast_tag,
  input  logic [VW-1:0] bcast_val,
  output logic [N-1:0]  ent_ready,
  input  logic [N-1:0]  grant,
  output logic          iss_valid,
  output logic [OW-1:0] iss_op,
  output logic [TW-1:0] iss_dst,
  output logic [VW-1:0] iss_a,
  output logic [VW-1:0] iss_b
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  occ, va, vb, vc;
  logic [OW-1:0] op_q  [N];
  logic [TW-1:0] dst_q [N];
  logic [TW-1:0] ta_q  [N];
  logic [TW-1:0] tb_q  [N];
  logic [TW-1:0] tc_q  [N];
  logic [VW-1:0] a_q   [N];
  logic [VW-1:0] b_q   [N];
  logic [IW-1:0] pick;
  logic [N-1:0]  fire;
  logic          wr;

  function automatic logic hit(input logic [TW-1:0] t);
    return bcast_valid && (t != '0) && (t == bcast_tag);
  endfunction

  assign full      = &occ;
  assign wr        = alloc_valid && !full;
  assign ent_ready = occ & va & vb & vc;
  assign fire      = grant & ent_ready;
  assign iss_valid = |fire;

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!occ[i]) pick = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      va  <= '0;
      vb  <= '0;
      vc  <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr && pick == IW'(i)) begin
          occ[i] <= 1'b1;
          va[i]  <= (alloc_a_tag == '0) || hit(alloc_a_tag);
          vb[i]  <= (alloc_b_tag == '0) || hit(alloc_b_tag);
          vc[i]  <= (alloc_c_tag == '0) || hit(alloc_c_tag);
        end else begin
          if (fire[i]) occ[i] <= 1'b0;
          if (occ[i] && hit(ta_q[i])) va[i] <= 1'b1;
          if (occ[i] && hit(tb_q[i])) vb[i] <= 1'b1;
          if (occ[i] && hit(tc_q[i])) vc[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (wr && pick == IW'(i)) begin
        op_q[i]  <= alloc_op;
        dst_q[i] <= alloc_dst;
        ta_q[i]  <= alloc_a_tag;
        tb_q[i]  <= alloc_b_tag;
        tc_q[i]  <= alloc_c_tag;
        a_q[i]   <= (alloc_a_tag != '0 && hit(alloc_a_tag)) ? bcast_val : alloc_a_val;
        b_q[i]   <= (alloc_b_tag != '0 && hit(alloc_b_tag)) ? bcast_val : alloc_b_val;
      end else begin
        if (occ[i] && !va[i] && hit(ta_q[i])) a_q[i] <= bcast_val;
        if (occ[i] && !vb[i] && hit(tb_q[i])) b_q[i] <= bcast_val;
      end
    end
  end

  always_comb begin
    iss_op  = '0;
    iss_dst = '0;
    iss_a   = '0;
    iss_b   = '0;
    for (int i = 0; i < N; i++) begin
      if (fire[i]) begin
        iss_op  = iss_op  | op_q[i];
        iss_dst = iss_dst | dst_q[i];
        iss_a   = iss_a   | a_q[i];
        iss_b   = iss_b   | b_q[i];
      end
    end
  end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         alloc_valid,
  input logic         full,
  input logic [N-1:0] grant,
  input logic [N-1:0] ent_ready
);
  p_onehot_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_full_refuses_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full && alloc_valid && !(|(grant & ent_ready)) |=> full);

  for (genvar i = 0; i < N; i++) begin : g_ent
    p_grant_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ent_ready[i] && grant[i] |=> !ent_ready[i]);
    p_ready_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ent_ready[i] && !grant[i] |=> ent_ready[i]);
  end
endmodule

bind rs_pool rs_pool_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .full(full),
  .grant(grant), .ent_ready(ent_ready)
);

// File: tb/tb_rs_pool.sv
module tb_rs_pool;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        alloc_valid = 0;
  logic [7:0]  alloc_op = 0;
  logic [5:0]  alloc_dst = 0, alloc_a_tag = 0, alloc_b_tag = 0, alloc_c_tag = 0;
  logic [31:0] alloc_a_val = 0, alloc_b_val = 0;
  logic        full;
  logic        bcast_valid = 0;
  logic [5:0]  bcast_tag = 0;
  logic [31:0] bcast_val = 0;
  logic [7:0]  ent_ready;
  logic [7:0]  grant = 0;
  logic        iss_valid;
  logic [7:0]  iss_op;
  logic [5:0]  iss_dst;
  logic [31:0] iss_a, iss_b;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic        v;
    logic [7:0]  op;
    logic [5:0]  dst;
    logic [31:0] a, b;
    string       req;
  } exp_t;
  exp_t q[$];
  exp_t e;

  rs_pool dut (.*);

  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic alloc(input logic [7:0] op, input logic [5:0] dst,
                       input logic [5:0] ta, input logic [31:0] av,
                       input logic [5:0] tb, input logic [31:0] bv,
                       input logic [5:0] tc);
    alloc_valid = 1; alloc_op = op; alloc_dst = dst;
    alloc_a_tag = ta; alloc_a_val = av; alloc_b_tag = tb; alloc_b_val = bv;
    alloc_c_tag = tc;
    step();
    alloc_valid = 0;
  endtask

  task automatic bcast(input logic v, input logic [5:0] t, input logic [31:0] d);
    bcast_valid = v; bcast_tag = t; bcast_val = d;
    step();
    bcast_valid = 0;
  endtask

  task automatic give(input int idx, input logic v, input logic [7:0] op,
                      input logic [5:0] dst, input logic [31:0] a,
                      input logic [31:0] b, input string req);
    exp_t x;
    x.v = v; x.op = op; x.dst = dst; x.a = a; x.b = b; x.req = req;
    q.push_back(x);
    grant = 8'(1) << idx;
    step();
    grant = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && grant != 0) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8: grant seen with no expected item, actual %0h expected queued item", grant);
      end else begin
        e = q.pop_front();
        chk({e.req, " iss_valid"}, 64'(iss_valid), 64'(e.v));
        if (e.v) begin
          chk({e.req, " iss_op"},  64'(iss_op),  64'(e.op));
          chk({e.req, " iss_dst"}, 64'(iss_dst), 64'(e.dst));
          chk({e.req, " iss_a"},   64'(iss_a),   64'(e.a));
          chk({e.req, " iss_b"},   64'(iss_b),   64'(e.b));
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1 ready", 64'(ent_ready), 64'h00);
    chk("R1 full", 64'(full), 64'h0);

    alloc(8'h11, 6'd1, 0, 32'h100, 0, 32'h101, 0);
    chk("R2 R4 slot0", 64'(ent_ready), 64'h01);
    alloc(8'h12, 6'd2, 6'd5, 32'h0, 0, 32'h201, 0);
    chk("R4 waiting", 64'(ent_ready), 64'h01);
    bcast(1, 6'd7, 32'hDEAD);
    chk("R5 mismatch", 64'(ent_ready), 64'h01);
    bcast(1, 6'd0, 32'hDEAD);
    chk("R10 tag zero", 64'(ent_ready), 64'h01);
    bcast(0, 6'd5, 32'hDEAD);
    chk("R10 not valid", 64'(ent_ready), 64'h01);
    bcast(1, 6'd5, 32'hAAAA);
    chk("R5 wake", 64'(ent_ready), 64'h03);

    alloc(8'h13, 6'd3, 6'd9, 32'h0, 6'd9, 32'h0, 0);
    chk("R5 both wait", 64'(ent_ready), 64'h03);
    bcast(1, 6'd9, 32'h9999);
    chk("R5 both wake", 64'(ent_ready), 64'h07);

    bcast_valid = 1; bcast_tag = 6'd12; bcast_val = 32'h1212;
    alloc(8'h14, 6'd4, 6'd12, 32'h0, 0, 32'h401, 0);
    bcast_valid = 0;
    chk("R6 same-cycle snoop", 64'(ent_ready), 64'h0F);

    alloc(8'h15, 6'd5, 0, 32'h500, 0, 32'h501, 6'd20);
    chk("R7 cond waits", 64'(ent_ready), 64'h0F);
    bcast(1, 6'd20, 32'hFFFF);
    chk("R7 cond wakes", 64'(ent_ready), 64'h1F);

    give(1, 1, 8'h12, 6'd2, 32'hAAAA, 32'h201, "R8 slot1");
    chk("R8 freed", 64'(ent_ready), 64'h1D);
    alloc(8'h16, 6'd6, 6'd30, 32'h0, 0, 32'h601, 0);
    chk("R2 reuse slot1", 64'(ent_ready), 64'h1D);
    give(1, 0, 0, 0, 0, 0, "R9 not ready");
    bcast(1, 6'd30, 32'h30303030);
    chk("R9 still occupied", 64'(ent_ready), 64'h1F);

    for (int k = 5; k < 8; k++)
      alloc(8'(8'h20 + k), 6'(10 + k), 0, 32'h5000 + k, 0, 32'h6000 + k, 0);
    chk("R3 all ready", 64'(ent_ready), 64'hFF);
    chk("R3 full", 64'(full), 64'h1);
    alloc(8'hEE, 6'd63, 0, 32'hEEEE, 0, 32'hEEEE, 0);
    chk("R3 refused full", 64'(full), 64'h1);
    give(0, 1, 8'h11, 6'd1, 32'h100, 32'h101, "R8 slot0");
    chk("R3 refused not stored", 64'(ent_ready), 64'hFE);
    chk("R3 full drops", 64'(full), 64'h0);
    alloc(8'h77, 6'd7, 0, 32'h700, 0, 32'h701, 0);
    chk("R2 refill slot0", 64'(ent_ready), 64'hFF);

    repeat (3) step();
    chk("R11 hold", 64'(ent_ready), 64'hFF);

    give(0, 1, 8'h77, 6'd7, 32'h700, 32'h701, "R8 slot0b");
    give(1, 1, 8'h16, 6'd6, 32'h30303030, 32'h601, "R5 slot1");
    give(2, 1, 8'h13, 6'd3, 32'h9999, 32'h9999, "R5 slot2");
    give(3, 1, 8'h14, 6'd4, 32'h1212, 32'h401, "R6 slot3");
    give(4, 1, 8'h15, 6'd5, 32'h500, 32'h501, "R7 slot4");
    for (int k = 5; k < 8; k++)
      give(k, 1, 8'(8'h20 + k), 6'(10 + k), 32'h5000 + k, 32'h6000 + k, "R8 tail");
    chk("R8 all freed", 64'(ent_ready), 64'h00);
    chk("R3 empty", 64'(full), 64'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule